// File: doc/BRIEF.md
# Pipelined Binary32 Multiplier

This block forms the product of two single-precision (binary32) floating-point operands in a fixed three-stage pipeline. A new operand pair may be presented on every clock with `valid_i` high. The packed result, an `valid_o` strobe and three condition flags (overflow, underflow, invalid) appear exactly three clocks later. Between results the output registers keep their last value.

The first stage classifies each operand and restores the hidden leading one of the significand. An operand whose exponent field is zero counts as zero, so subnormals are flushed. An operand whose exponent field is all ones (infinity or NaN) makes the pair invalid. The second stage forms the sign, the rebiased exponent sum and the full-width significand product. When a pair is zero or invalid, this stage skips the arithmetic and passes the class down the pipeline. The third stage normalises the product, rounds it to nearest with ties to even, checks the exponent range and packs the result.

Top module: `fpmul_pipe`

## Requirements
- R1: An input pair accepted with `valid_i`=1 on clock edge n produces `valid_o`=1 together with its result after edge n+3. One pair is accepted on every cycle, with no bubbles needed between pairs.
- R2: Cycles with `valid_i`=0 produce no output strobe. Operand values presented in those cycles change neither `result_o` nor any flag: these outputs keep their last value while `valid_o` is 0.
- R3: If either exponent field (bits 30..23) is 0 and neither is 255, the result is a zero whose sign (bit 31) is the XOR of the operand signs. All three flags are 0 in this case.
- R4: For every result that is not invalid, bit 31 of the result is the XOR of bit 31 of the two operands.
- R5: For normal operands, the result exponent is E1+E2-127. The result fraction holds the 23 bits that follow the leading one of the 48-bit product of the two 24-bit significands.
- R6: When bit 47 of the significand product is set, the product is taken one place further right and the exponent is incremented by one.
- R7: Rounding is to nearest. It uses a guard bit and a sticky bit below the kept fraction. An exact tie rounds to the value whose fraction LSB is 0.
- R8: A rounding increment that overflows the 24-bit significand gives a fraction of 0 and adds one more to the exponent.
- R9: If the final exponent is 255 or more, `overflow_o`=1 and the result is infinity with the product sign: exponent 255, fraction 0.
- R10: If the final exponent is 0 or less, `underflow_o`=1 and the result is zero with the product sign.
- R11: If either operand has exponent field 255, `invalid_o`=1 and the result is 0x7FC00000. This takes priority over the zero case, and the other two flags are 0. At most one of the three flags is high at any time.
- R12: While `rst_ni` is low, and after it, until the first result arrives: `valid_o` is 0, `result_o` is 0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair present |
| a_i | input | 32 | First binary32 operand |
| b_i | input | 32 | Second binary32 operand |
| valid_o | output | 1 | Result present, three cycles after its input |
| result_o | output | 32 | Binary32 product |
| overflow_o | output | 1 | Product exponent above the normal range |
| underflow_o | output | 1 | Product exponent below the normal range |
| invalid_o | output | 1 | An operand was infinity or NaN |

## Verification
The bench builds the block with its default exponent width of 8 and fraction width of 23, the binary32 layout. All expected encodings are therefore exact hexadecimal values. The vectors reach both rounding directions of an exact tie, and a round-up that carries into the exponent. They also reach the largest normal value, the first exponent that overflows, the smallest normal value and the first exponent that underflows. The vectors are streamed back to back and again with idle gaps, so that latency and holding are both observed.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;

  typedef enum logic [1:0] {
    CLS_NUM  = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_INV  = 2'd2
  } op_cls_e;

  // invalid wins over zero
  function automatic op_cls_e merge_cls(input logic zero_a, input logic zero_b,
                                        input logic spec_a, input logic spec_b);
    if (spec_a || spec_b) return CLS_INV;
    if (zero_a || zero_b) return CLS_ZERO;
    return CLS_NUM;
  endfunction

endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
  import fpmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [EXP_W+FRAC_W:0]       a_i,
  input  logic [EXP_W+FRAC_W:0]       b_i,
  output logic                        valid_o,
  output op_cls_e                     cls_o,
  output logic                        sign_o,
  output logic [EXP_W-1:0]            exp_a_o,
  output logic [EXP_W-1:0]            exp_b_o,
  output logic [FRAC_W:0]             sig_a_o,
  output logic [FRAC_W:0]             sig_b_o
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;

  logic [W-1:0]     ops    [2];
  logic [EXP_W-1:0] exp_f  [2];
  logic [SIG_W-1:0] sig_f  [2];
  logic             zero_v [2];
  logic             spec_v [2];

  assign ops[0] = a_i;
  assign ops[1] = b_i;

  for (genvar k = 0; k < 2; k++) begin : g_op
    assign exp_f[k]  = ops[k][W-2 -: EXP_W];
    assign zero_v[k] = (exp_f[k] == '0);
    assign spec_v[k] = &exp_f[k];
    assign sig_f[k]  = {1'b1, ops[k][FRAC_W-1:0]};
  end

  op_cls_e cls_c;
  assign cls_c = merge_cls(zero_v[0], zero_v[1], spec_v[0], spec_v[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cls_o   <= CLS_ZERO;
      sign_o  <= 1'b0;
      exp_a_o <= '0;
      exp_b_o <= '0;
      sig_a_o <= '0;
      sig_b_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        cls_o  <= cls_c;
        sign_o <= a_i[W-1] ^ b_i[W-1];
        if (cls_c == CLS_NUM) begin
          exp_a_o <= exp_f[0];
          exp_b_o <= exp_f[1];
          sig_a_o <= sig_f[0];
          sig_b_o <= sig_f[1];
        end else begin
          exp_a_o <= '0;
          exp_b_o <= '0;
          sig_a_o <= '0;
          sig_b_o <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/fpm_mult.sv
module fpm_mult
  import fpmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  op_cls_e                      cls_i,
  input  logic                         sign_i,
  input  logic [EXP_W-1:0]             exp_a_i,
  input  logic [EXP_W-1:0]             exp_b_i,
  input  logic [FRAC_W:0]              sig_a_i,
  input  logic [FRAC_W:0]              sig_b_i,
  output logic                         valid_o,
  output op_cls_e                      cls_o,
  output logic                         sign_o,
  output logic signed [EXP_W+1:0]      exp_o,
  output logic [2*FRAC_W+1:0]          prod_o
);
  localparam int XW     = EXP_W + 2;
  localparam int PROD_W = 2 * (FRAC_W + 1);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [XW-1:0] BIAS_X = XW'(BIAS);

  logic signed [XW-1:0] esum_c;
  logic [PROD_W-1:0]    prod_c;

  // two guard bits keep the sum in range for the widest operands
  assign esum_c = $signed({2'b00, exp_a_i}) + $signed({2'b00, exp_b_i}) - BIAS_X;
  assign prod_c = PROD_W'(sig_a_i) * PROD_W'(sig_b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cls_o   <= CLS_ZERO;
      sign_o  <= 1'b0;
      exp_o   <= '0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        cls_o  <= cls_i;
        sign_o <= sign_i;
        if (cls_i == CLS_NUM) begin
          exp_o  <= esum_c;
          prod_o <= prod_c;
        end else begin
          exp_o  <= '0;
          prod_o <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/fpm_norm.sv
module fpm_norm
  import fpmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  op_cls_e                      cls_i,
  input  logic                         sign_i,
  input  logic signed [EXP_W+1:0]      exp_i,
  input  logic [2*FRAC_W+1:0]          prod_i,
  output logic                         valid_o,
  output logic [EXP_W+FRAC_W:0]        result_o,
  output logic                         overflow_o,
  output logic                         underflow_o,
  output logic                         invalid_o
);
  localparam int XW     = EXP_W + 2;
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int PROD_W = 2 * (FRAC_W + 1);
  localparam logic signed [XW-1:0] EMAX_X = XW'((1 << EXP_W) - 1);
  localparam logic signed [XW-1:0] ONE_X  = XW'(1);
  localparam logic [W-2:0] QNAN_MAG = {{EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-2:0] INF_MAG  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic                 top_c, guard_c, sticky_c, rnd_c, carry_c;
  logic [FRAC_W-1:0]    kept_c;
  logic [FRAC_W:0]      frac_r_c;
  logic [FRAC_W-1:0]    frac_c;
  logic signed [XW-1:0] exp_n_c, exp_f_c;
  logic                 ovf_c, unf_c;
  logic [W-1:0]         res_c;

  assign top_c    = prod_i[PROD_W-1];
  assign kept_c   = top_c ? prod_i[PROD_W-2 -: FRAC_W] : prod_i[PROD_W-3 -: FRAC_W];
  assign guard_c  = top_c ? prod_i[FRAC_W] : prod_i[FRAC_W-1];
  assign sticky_c = top_c ? (|prod_i[FRAC_W-1:0]) : (|prod_i[FRAC_W-2:0]);
  assign exp_n_c  = exp_i + XW'(top_c);

  // nearest, ties to even
  assign rnd_c    = guard_c & (sticky_c | kept_c[0]);
  assign frac_r_c = {1'b0, kept_c} + (FRAC_W+1)'(rnd_c);
  assign carry_c  = frac_r_c[FRAC_W];
  assign frac_c   = carry_c ? '0 : frac_r_c[FRAC_W-1:0];
  assign exp_f_c  = exp_n_c + XW'(carry_c);

  assign ovf_c = (exp_f_c >= EMAX_X);
  assign unf_c = (exp_f_c < ONE_X);

  always_comb begin
    unique case (cls_i)
      CLS_INV:  res_c = {1'b0, QNAN_MAG};
      CLS_ZERO: res_c = {sign_i, {(W-1){1'b0}}};
      default: begin
        if (ovf_c)      res_c = {sign_i, INF_MAG};
        else if (unf_c) res_c = {sign_i, {(W-1){1'b0}}};
        else            res_c = {sign_i, exp_f_c[EXP_W-1:0], frac_c};
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      invalid_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o    <= res_c;
        invalid_o   <= (cls_i == CLS_INV);
        overflow_o  <= (cls_i == CLS_NUM) && ovf_c;
        underflow_o <= (cls_i == CLS_NUM) && !ovf_c && unf_c;
      end
    end
  end

endmodule

// File: rtl/fpmul_pipe.sv
module fpmul_pipe
  import fpmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [EXP_W+FRAC_W:0]  a_i,
  input  logic [EXP_W+FRAC_W:0]  b_i,
  output logic                   valid_o,
  output logic [EXP_W+FRAC_W:0]  result_o,
  output logic                   overflow_o,
  output logic                   underflow_o,
  output logic                   invalid_o
);
  localparam int XW     = EXP_W + 2;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;

  logic              s1_valid, s1_sign;
  op_cls_e           s1_cls;
  logic [EXP_W-1:0]  s1_exp_a, s1_exp_b;
  logic [SIG_W-1:0]  s1_sig_a, s1_sig_b;

  logic                 s2_valid, s2_sign;
  op_cls_e              s2_cls;
  logic signed [XW-1:0] s2_exp;
  logic [PROD_W-1:0]    s2_prod;

  fpm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .valid_o (s1_valid),
    .cls_o   (s1_cls),
    .sign_o  (s1_sign),
    .exp_a_o (s1_exp_a),
    .exp_b_o (s1_exp_b),
    .sig_a_o (s1_sig_a),
    .sig_b_o (s1_sig_b)
  );

  fpm_mult #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mult (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .cls_i   (s1_cls),
    .sign_i  (s1_sign),
    .exp_a_i (s1_exp_a),
    .exp_b_i (s1_exp_b),
    .sig_a_i (s1_sig_a),
    .sig_b_i (s1_sig_b),
    .valid_o (s2_valid),
    .cls_o   (s2_cls),
    .sign_o  (s2_sign),
    .exp_o   (s2_exp),
    .prod_o  (s2_prod)
  );

  fpm_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (s2_valid),
    .cls_i       (s2_cls),
    .sign_i      (s2_sign),
    .exp_i       (s2_exp),
    .prod_i      (s2_prod),
    .valid_o     (valid_o),
    .result_o    (result_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o),
    .invalid_o   (invalid_o)
  );

endmodule

// File: rtl/fpmul_pipe_chk.sv
module fpmul_pipe_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic [EXP_W+FRAC_W:0] a_i,
  input logic [EXP_W+FRAC_W:0] b_i,
  input logic                  valid_o,
  input logic [EXP_W+FRAC_W:0] result_o,
  input logic                  overflow_o,
  input logic                  underflow_o,
  input logic                  invalid_o
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [1:0] cyc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != 2'd0 && !valid_o) |-> ($stable(result_o) && $stable(overflow_o) &&
                                   $stable(underflow_o) && $stable(invalid_o)));

  assert_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3 && valid_o && !invalid_o &&
     ($past(a_i[W-2 -: EXP_W], 3) == '0 || $past(b_i[W-2 -: EXP_W], 3) == '0))
    |-> (result_o[W-2:0] == '0 && !overflow_o && !underflow_o));

  assert_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3 && valid_o && !invalid_o)
    |-> (result_o[W-1] == ($past(a_i[W-1], 3) ^ $past(b_i[W-1], 3))));

  assert_ovf_inf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (result_o[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  assert_unf_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> (result_o[W-2:0] == '0));

  assert_flags_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({overflow_o, underflow_o, invalid_o}));

  assert_inv_nan_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (result_o == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}));

endmodule

bind fpmul_pipe fpmul_pipe_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .valid_o     (valid_o),
  .result_o    (result_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o),
  .invalid_o   (invalid_o)
);

// File: tb/fpmul_pipe_bench.sv
module fpmul_pipe_bench;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int NV     = 23;
  localparam int WDOG   = 5000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         valid_o, overflow_o, underflow_o, invalid_o;
  logic [W-1:0] result_o;

  always #10 clk = ~clk;

  fpmul_pipe #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fpmul_pipe (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_o), .result_o(result_o), .overflow_o(overflow_o),
    .underflow_o(underflow_o), .invalid_o(invalid_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // fl = {invalid, overflow, underflow}
  typedef struct packed {
    logic [7:0]   req;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] res;
    logic [2:0]   fl;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{8'd5,  32'h3F800000, 32'h3F800000, 32'h3F800000, 3'b000}, // R5 1*1
    '{8'd5,  32'h40000000, 32'h40400000, 32'h40C00000, 3'b000}, // R5 2*3
    '{8'd4,  32'hBFC00000, 32'h3FC00000, 32'hC0100000, 3'b000}, // R4 R6 -1.5*1.5
    '{8'd6,  32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 3'b000}, // R6
    '{8'd7,  32'h3FC00000, 32'h3F800001, 32'h3FC00002, 3'b000}, // R7 tie, odd -> up
    '{8'd7,  32'h3FC00000, 32'h3F800003, 32'h3FC00004, 3'b000}, // R7 tie, even -> stay
    '{8'd7,  32'h3F800001, 32'h3F800001, 32'h3F800002, 3'b000}, // R7 below half
    '{8'd8,  32'h3FFFFFFE, 32'h3F800001, 32'h40000000, 3'b000}, // R8 carry renorm
    '{8'd3,  32'h00000000, 32'h40A00000, 32'h00000000, 3'b000}, // R3
    '{8'd3,  32'h80000000, 32'h40400000, 32'h80000000, 3'b000}, // R3 signed zero
    '{8'd3,  32'h00000001, 32'h3F800000, 32'h00000000, 3'b000}, // R3 subnormal flushed
    '{8'd9,  32'h7F000000, 32'h7F000000, 32'h7F800000, 3'b010}, // R9
    '{8'd9,  32'hFF000000, 32'h7F000000, 32'hFF800000, 3'b010}, // R9 negative
    '{8'd9,  32'h7F000000, 32'h40000000, 32'h7F800000, 3'b010}, // R9 exp exactly 255
    '{8'd5,  32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 3'b000}, // R5 largest normal
    '{8'd10, 32'h00800000, 32'h00800000, 32'h00000000, 3'b001}, // R10
    '{8'd10, 32'h80800000, 32'h00800000, 32'h80000000, 3'b001}, // R10 negative
    '{8'd10, 32'h00800000, 32'h3F000000, 32'h00000000, 3'b001}, // R10 exp exactly 0
    '{8'd11, 32'h7F800000, 32'h3F800000, 32'h7FC00000, 3'b100}, // R11 inf
    '{8'd11, 32'h7F800000, 32'h00000000, 32'h7FC00000, 3'b100}, // R11 over zero
    '{8'd11, 32'h7FC00000, 32'hBF800000, 32'h7FC00000, 3'b100}, // R11 NaN
    '{8'd5,  32'h00800000, 32'h3F800000, 32'h00800000, 3'b000}, // R5 smallest normal
    '{8'd9,  32'h7F7FFFFF, 32'h3F800001, 32'h7F800000, 3'b010}  // R9 via normalization
  };

  vec_t exp_q   [64];
  int   exp_cyc [64];
  int   wr = 0, rd = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic drive(input vec_t v);
    a_i     = v.a;
    b_i     = v.b;
    valid_i = 1'b1;
    exp_q[wr]   = v;
    exp_cyc[wr] = cyc;
    wr++;
  endtask

  // output monitor: latency (R1) and value per vector
  always @(negedge clk) begin
    if (rst_n && valid_o && !done) begin
      if (rd >= wr) begin
        check("R1 unexpected strobe", 64'd1, 64'd0);
      end else begin
        check("R1 latency", 64'(cyc), 64'(exp_cyc[rd] + 3));
        check($sformatf("R%0d vec a=%h b=%h", exp_q[rd].req, exp_q[rd].a, exp_q[rd].b),
              64'({result_o, invalid_o, overflow_o, underflow_o}),
              64'({exp_q[rd].res, exp_q[rd].fl}));
        rd++;
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    if (cyc == WDOG && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  initial begin
    logic [W+2:0] held;
    repeat (3) @(negedge clk);
    // R12 during reset
    check("R12 in reset", 64'({valid_o, result_o, overflow_o, underflow_o, invalid_o}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 after reset", 64'({valid_o, result_o, overflow_o, underflow_o, invalid_o}), 64'd0);

    // back to back stream (R1 throughput)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
    end
    valid_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 all results back-to-back", 64'(rd), 64'(wr));

    // R2: idle inputs with operand garbage do not disturb the outputs
    held = {result_o, overflow_o, underflow_o, invalid_o};
    for (int j = 0; j < 6; j++) begin
      a_i = (j % 2 == 0) ? 32'h7F800000 : 32'h00000000;
      b_i = 32'h3F800000 + 32'(j);
      @(negedge clk);
      check("R2 no strobe when idle", 64'(valid_o), 64'd0);
      check("R2 outputs held", 64'({result_o, overflow_o, underflow_o, invalid_o}), 64'(held));
    end

    // stream with idle gaps
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      valid_i = 1'b0;
      a_i = 32'hFFFFFFFF;
      b_i = 32'h00000000;
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
    check("R1 all results with gaps", 64'(rd), 64'(wr));

    done = 1'b1;
    summary();
    $finish;
  end

endmodule